// File: doc/BRIEF.md
# Configurable FIFO Pointer and Level Flag Controller

This block keeps the write and read address counters of a FIFO that is built from 4K-bit RAM blocks, and derives the FULL, EMPTY, almost-full and almost-empty flags from them. The blocks can be used at one of six word widths, and one to sixteen of them can be chained. Two static selects pick the width and the chain depth. Together they decide which counter bits are live. The lowest live bit moves down as words get narrower. The highest live bit moves up as more blocks are chained, and the bits above bit 11 then name the RAM block being addressed.

The two 8-bit thresholds are compared against the occupancy difference at bits [15:8]. Only as many threshold bits take part as the chain depth makes live. All outputs come from registers. The flags are refreshed on the same clock edge as the counters, so the addresses and flags seen in any cycle always agree. The RAM arrays and the data path sit outside this block. A change to either select should be followed by a reset.

Top module: `fifo_flag_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both address outputs and both block outputs become 0, `empty` becomes 1 and `full` becomes 0.
- R2: `width_sel` codes 0,1,2,3,4,5 (x1,x2,x4,x9,x18,x36) set the lowest live counter bit to 0,1,2,3,4,5; codes 6 and 7 act as 5. Each accepted write, or read, adds 1 at that bit of its counter.
- R3: `casc_sel` codes 0,1,2,3,4 (1,2,4,8,16 blocks) set the highest live counter bit to 11,12,13,14,15; codes above 4 act as 4. A counter wraps to 0 past its highest live bit. `wr_blk`/`rd_blk` carry counter bits [15:12].
- R4: Counter bits outside the live range always read 0.
- R5: The FIFO holds 2^(highest-lowest+1) words. `full` is 1 exactly when that many words are stored, and a write while `full` is 1 leaves the write counter unchanged.
- R6: `empty` is 1 exactly when no words are stored, and a read while `empty` is 1 leaves the read counter unchanged.
- R7: A write and a read in the same cycle, when neither is blocked, both advance and leave the occupancy unchanged.
- R8: The compare value is bits [15:8] of (write counter − read counter), taken over the live range. `afull` is 1 when the compare value ≥ `af_thresh` with only its low 4+`casc_sel` bits kept.
- R9: `aempty` is 1 when the compare value ≤ `ae_thresh`, with the same masking as in R8.
- R10: While the FIFO is full, the compare value is the all-ones value of the kept threshold bits.
- R11: The flags are registered and reflect the counters present in the same cycle, together with the thresholds sampled at the edge that produced those counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 3 | Word-width code (static) |
| casc_sel | input | 3 | Chain-depth code (static) |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| af_thresh | input | 8 | Almost-full threshold |
| ae_thresh | input | 8 | Almost-empty threshold |
| wr_addr | output | 16 | Masked write counter |
| rd_addr | output | 16 | Masked read counter |
| wr_blk | output | 4 | Write RAM block select |
| rd_blk | output | 4 | Read RAM block select |
| full | output | 1 | FIFO full |
| empty | output | 1 | FIFO empty |
| afull | output | 1 | Almost full |
| aempty | output | 1 | Almost empty |

## Verification
The counters and flags are driven through complete fill, overfill, drain, overdrain and wrap sequences at several width and chain-depth pairs. This separates the step size given by the lowest live bit from the wrap point given by the highest live bit. A x4 run with four blocks chained crosses RAM-block boundaries, which shows whether the block-select bits step correctly. Threshold runs use values with junk in the masked-off upper bits, so that masking errors become visible. Runs with simultaneous reads and writes show whether the occupancy stays put while both counters move on.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  localparam int CNT_W    = 16;            // visible counter width
  localparam int XW       = CNT_W + 1;     // counter plus wrap bit
  localparam int THR_W    = 8;             // threshold width
  localparam int DIFF_LSB = 8;             // difference bit aligned to threshold bit 0
  localparam int BASE_TOP = 11;            // highest live bit with no chaining
  localparam int MAX_LO   = 5;             // lowest live bit for the widest word
  localparam int MAX_CASC = 4;             // log2 of the deepest chain
  localparam int CFG_W    = 3;
  localparam int BLK_LSB  = BASE_TOP + 1;
  localparam int BLK_W    = CNT_W - BLK_LSB;

  typedef struct packed {
    logic [XW-1:0]    act_mask;  // live counter bits
    logic [XW-1:0]    ext_mask;  // live bits plus wrap bit
    logic [XW-1:0]    step;      // one unit at the lowest live bit
    logic [XW-1:0]    wrap_bit;  // bit just above the live range
    logic [THR_W-1:0] thr_mask;  // threshold bits that take part
  } cfg_t;
endpackage

// File: rtl/fifo_cfg_decode.sv
module fifo_cfg_decode
  import fifo_flag_pkg::*;
(
  input  logic [CFG_W-1:0] width_sel,
  input  logic [CFG_W-1:0] casc_sel,
  output cfg_t             cfg
);
  int lo_bit;
  int hi_bit;

  always_comb begin
    lo_bit = (int'(width_sel) > MAX_LO)   ? MAX_LO : int'(width_sel);
    hi_bit = BASE_TOP + ((int'(casc_sel) > MAX_CASC) ? MAX_CASC : int'(casc_sel));
    for (int i = 0; i < XW; i++) begin
      cfg.act_mask[i] = (i >= lo_bit) && (i <= hi_bit);
      cfg.ext_mask[i] = (i >= lo_bit) && (i <= hi_bit + 1);
      cfg.step[i]     = (i == lo_bit);
      cfg.wrap_bit[i] = (i == hi_bit + 1);
    end
    for (int j = 0; j < THR_W; j++) begin
      cfg.thr_mask[j] = (j + DIFF_LSB) <= hi_bit;
    end
  end
endmodule

// File: rtl/fifo_addr_ctr.sv
module fifo_addr_ctr
  import fifo_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [XW-1:0] step,
  input  logic [XW-1:0] ext_mask,
  output logic [XW-1:0] cnt,
  output logic [XW-1:0] cnt_nxt
);
  always_comb begin
    if (rst)      cnt_nxt = '0;
    else if (adv) cnt_nxt = (cnt + step) & ext_mask;
    else          cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    cnt <= cnt_nxt;
  end

  // R2: an accepted access adds one unit at the lowest live bit
  a_r2_step_advance: assert property (@(posedge clk) disable iff (rst)
    adv |=> cnt == (($past(cnt) + $past(step)) & $past(ext_mask)));

  // R2: no access, no movement
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags
  import fifo_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic [XW-1:0]    wr_nxt,
  input  logic [XW-1:0]    rd_nxt,
  input  logic [THR_W-1:0] af_thresh,
  input  logic [THR_W-1:0] ae_thresh,
  output logic             full,
  output logic             empty,
  output logic             afull,
  output logic             aempty
);
  logic [XW-1:0]    diff;
  logic             full_d;
  logic             empty_d;
  logic [THR_W-1:0] cmp_val;
  logic [THR_W-1:0] af_m;
  logic [THR_W-1:0] ae_m;

  always_comb begin
    diff    = (wr_nxt - rd_nxt) & cfg.ext_mask;
    full_d  = (diff == cfg.wrap_bit);
    empty_d = (diff == '0);
    cmp_val = full_d ? cfg.thr_mask : (diff[DIFF_LSB +: THR_W] & cfg.thr_mask);
    af_m    = af_thresh & cfg.thr_mask;
    ae_m    = ae_thresh & cfg.thr_mask;
  end

  always_ff @(posedge clk) begin
    full   <= full_d;
    empty  <= empty_d;
    afull  <= (cmp_val >= af_m);
    aempty <= (cmp_val <= ae_m);
  end

  // R10: a full FIFO is always almost full
  a_r10_full_is_afull: assert property (@(posedge clk) disable iff (rst)
    full |-> afull);

  // R9: an empty FIFO is always almost empty
  a_r9_empty_is_aempty: assert property (@(posedge clk) disable iff (rst)
    empty |-> aempty);
endmodule

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fifo_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_W-1:0]    width_sel,
  input  logic [CFG_W-1:0]    casc_sel,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [THR_W-1:0]    af_thresh,
  input  logic [THR_W-1:0]    ae_thresh,
  output logic [CNT_W-1:0]    wr_addr,
  output logic [CNT_W-1:0]    rd_addr,
  output logic [BLK_W-1:0]    wr_blk,
  output logic [BLK_W-1:0]    rd_blk,
  output logic                full,
  output logic                empty,
  output logic                afull,
  output logic                aempty
);
  cfg_t          cfg;
  logic          wr_ok;
  logic          rd_ok;
  logic [XW-1:0] wr_cnt, wr_nxt;
  logic [XW-1:0] rd_cnt, rd_nxt;

  fifo_cfg_decode u_dec (
    .width_sel (width_sel),
    .casc_sel  (casc_sel),
    .cfg       (cfg)
  );

  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  fifo_addr_ctr u_wr_ctr (
    .clk      (clk),
    .rst      (rst),
    .adv      (wr_ok),
    .step     (cfg.step),
    .ext_mask (cfg.ext_mask),
    .cnt      (wr_cnt),
    .cnt_nxt  (wr_nxt)
  );

  fifo_addr_ctr u_rd_ctr (
    .clk      (clk),
    .rst      (rst),
    .adv      (rd_ok),
    .step     (cfg.step),
    .ext_mask (cfg.ext_mask),
    .cnt      (rd_cnt),
    .cnt_nxt  (rd_nxt)
  );

  fifo_level_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .wr_nxt    (wr_nxt),
    .rd_nxt    (rd_nxt),
    .af_thresh (af_thresh),
    .ae_thresh (ae_thresh),
    .full      (full),
    .empty     (empty),
    .afull     (afull),
    .aempty    (aempty)
  );

  assign wr_addr = wr_cnt[CNT_W-1:0] & cfg.act_mask[CNT_W-1:0];
  assign rd_addr = rd_cnt[CNT_W-1:0] & cfg.act_mask[CNT_W-1:0];
  assign wr_blk  = wr_addr[CNT_W-1:BLK_LSB];
  assign rd_blk  = rd_addr[CNT_W-1:BLK_LSB];

  // R4: dead bits never set in the stored counters
  a_r4_dead_bits_zero: assert property (@(posedge clk) disable iff (rst)
    ((wr_cnt | rd_cnt) & ~cfg.ext_mask) == '0);

  // R5: a blocked write leaves the write address alone
  a_r5_no_wr_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> wr_addr == $past(wr_addr));

  // R6: a blocked read leaves the read address alone
  a_r6_no_rd_when_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> rd_addr == $past(rd_addr));

  // R11: the two end flags never coexist
  a_r11_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: tb/fifo_flag_ctrl_tb.sv
module fifo_flag_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  width_sel = '0;
  logic [2:0]  casc_sel = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  af_thresh = 8'hFF;
  logic [7:0]  ae_thresh = 8'h00;
  logic [15:0] wr_addr, rd_addr;
  logic [3:0]  wr_blk, rd_blk;
  logic        full, empty, afull, aempty;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  int lo, cs, cap, wcnt, rcnt, occ;

  always #10 clk = ~clk;  // 50 MHz

  fifo_flag_ctrl dut_i (
    .clk(clk), .rst(rst), .width_sel(width_sel), .casc_sel(casc_sel),
    .wr_en(wr_en), .rd_en(rd_en), .af_thresh(af_thresh), .ae_thresh(ae_thresh),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_blk(wr_blk), .rd_blk(rd_blk),
    .full(full), .empty(empty), .afull(afull), .aempty(aempty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int tm, cmp, ea, er;
    tm  = (1 << (4 + cs)) - 1;
    cmp = (occ == cap) ? tm : ((occ << lo) >> 8) & tm;
    ea  = (wcnt % cap) << lo;
    er  = (rcnt % cap) << lo;
    chk("R2 R4 wr_addr", int'(wr_addr), ea);
    chk("R2 R4 rd_addr", int'(rd_addr), er);
    chk("R3 wr_blk", int'(wr_blk), ea >> 12);
    chk("R3 rd_blk", int'(rd_blk), er >> 12);
    chk("R5 full", int'(full), int'(occ == cap));
    chk("R6 empty", int'(empty), int'(occ == 0));
    chk("R8 R10 afull", int'(afull), int'(cmp >= (int'(af_thresh) & tm)));
    chk("R9 R11 aempty", int'(aempty), int'(cmp <= (int'(ae_thresh) & tm)));
  endtask

  task automatic do_reset(input int w, input int c);
    @(negedge clk);
    width_sel = 3'(w); casc_sel = 3'(c);
    lo = (w > 5) ? 5 : w;
    cs = (c > 4) ? 4 : c;
    cap = 1 << (12 + cs - lo);
    rst = 1'b1; wr_en = 0; rd_en = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    wcnt = 0; rcnt = 0; occ = 0;
    check_all();  // R1
    chk("R1 reset empty", int'(empty), 1);
    chk("R1 reset full", int'(full), 0);
  endtask

  task automatic step(input bit w, input bit r);
    bit wa, ra;
    wr_en = w; rd_en = r;
    wa = w && (occ != cap);
    ra = r && (occ != 0);
    @(posedge clk); @(negedge clk);
    if (wa) begin wcnt = (wcnt + 1) % cap; occ++; end
    if (ra) begin rcnt = (rcnt + 1) % cap; occ--; end
    wr_en = 0; rd_en = 0;
    check_all();
  endtask

  // R5 R6 R3: fill past full, drain past empty, then wrap
  task automatic t_fill_drain(input int w, input int c);
    do_reset(w, c);
    for (int i = 0; i < cap + 2; i++) step(1, 0);
    chk("R5 full after fill", int'(full), 1);
    for (int i = 0; i < cap + 2; i++) step(0, 1);
    chk("R6 empty after drain", int'(empty), 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R3 wrapped wr_addr", int'(wr_addr), 5 << lo);
  endtask

  // R3: x4 with four blocks crosses block boundaries
  task automatic t_blocks();
    do_reset(2, 2);
    for (int i = 0; i < 1100; i++) step(1, 0);
    chk("R3 wr_blk after 1100 writes", int'(wr_blk), 1);
    for (int i = 0; i < 1030; i++) step(0, 1);
    chk("R3 rd_blk after 1030 reads", int'(rd_blk), 1);
  endtask

  // R8 R9 R10: thresholds with junk in masked-off upper bits
  task automatic t_thresh();
    af_thresh = 8'hF5; ae_thresh = 8'h32;
    do_reset(5, 0);
    for (int i = 0; i < 60; i++) step(1, 0);
    chk("R8 afull at 60 words", int'(afull), 1);
    for (int i = 0; i < 45; i++) step(0, 1);
    chk("R9 aempty at 15 words", int'(aempty), 1);
    af_thresh = 8'h10; ae_thresh = 8'h03;
    do_reset(5, 4);
    for (int i = 0; i < 140; i++) step(1, 0);
    chk("R8 afull casc16 at 140", int'(afull), 1);
    af_thresh = 8'hFF; ae_thresh = 8'h00;
  endtask

  // R7: simultaneous accesses
  task automatic t_simul();
    do_reset(4, 1);
    for (int i = 0; i < 10; i++) step(1, 0);
    for (int i = 0; i < 40; i++) step(1, 1);
    chk("R7 occupancy held", int'(wr_addr - rd_addr), 10 << 4);
    step(0, 1);
    for (int i = 0; i < 9; i++) step(1, 1);
  endtask

  initial begin
    do_reset(0, 0);
    t_fill_drain(5, 0);
    t_fill_drain(4, 1);
    t_fill_drain(7, 6);  // R2 R3 clamp: acts as x36 with 16 blocks
    t_blocks();
    t_thresh();
    t_simul();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule